// File: doc/BRIEF.md
# Market-Data Message Parser

This block sits behind a UDP receiver and decodes one binary market-data message per UDP payload. Each payload byte is held on the input for two consecutive clocks. A start flag marks the first copy of the leading type byte, and an end flag marks the final byte. The parser latches the type and looks up the total length for that type. It then counts clock cycles and copies big-endian fields into output registers at fixed byte offsets. When the final byte has been taken, it raises a message-valid pulse together with a one-hot pulse that tells which type arrived.

Field registers are never cleared after a message. They keep their values until a later message writes the same field, so logic in a slower clock domain has time to sample them. An unknown type byte, or an end flag that arrives before the full length, sends the parser through an error state that bumps a saturating error counter. A start flag seen in the same cycle as the completion pulse begins the next message immediately.

Top module: `mdp_parser`

## Requirements
- R1: After reset, every output is zero: valid pulses, type, all field registers and the error count.
- R2: The supported types are 0x41 (36 bytes), 0x45 (31), 0x58 (23), 0x53 (12) and 0x52 (39), counting the type byte. A complete message raises `o_msg_valid` for exactly one cycle, in the cycle after the clock edge that samples the first copy of its final byte. `o_msg_type` holds the most recently started type byte.
- R3: While `o_msg_valid` is high, `o_kind_valid` is one-hot: bit 0 for 0x41, bit 1 for 0x45, bit 2 for 0x58, bit 3 for 0x53, bit 4 for 0x52. At all other times it is zero.
- R4: Payload byte N is taken from the first of its two input cycles, which is when the internal cycle counter equals 2N-1. The second copy of every byte is ignored, and so is the repeated copy of the type byte.
- R5: Type 0x41 fills the order reference from bytes 11-18, the side from byte 19, the quantity from bytes 20-23, the symbol from bytes 24-31 and the price from bytes 32-35. Multi-byte fields are big-endian: the lowest byte number is the most significant.
- R6: Type 0x45 fills the order reference from bytes 11-18, the quantity from bytes 19-22 and the match id from bytes 23-30. Type 0x58 fills the order reference from bytes 11-18 and the quantity from bytes 19-22.
- R7: Type 0x53 fills the event code from byte 11. Type 0x52 fills the symbol from bytes 11-18, the market category from byte 19, the financial status from byte 20 and the lot size from bytes 21-24.
- R8: Field registers keep their values through idle cycles and through messages of types that do not write them. Input bytes that arrive without a start flag are ignored.
- R9: A start with an unrecognized type byte produces no valid pulse and raises the error count by one.
- R10: An end flag before the expected length produces no valid pulse and raises the error count by one. Bytes already taken from the message stay in the field registers.
- R11: The error count saturates at all ones.
- R12: A start flag that arrives in the cycle where `o_msg_valid` is high begins the next message without losing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_start | input | 1 | First copy of a payload's type byte |
| in_valid | input | 1 | Qualifies start and end flags |
| in_end | input | 1 | Final byte of the payload |
| in_data | input | 8 | Payload byte, held for two clocks |
| o_msg_valid | output | 1 | One-cycle completion pulse |
| o_kind_valid | output | 5 | One-hot per-type completion pulse |
| o_msg_type | output | 8 | Latched type byte |
| o_order_ref | output | 64 | Order reference |
| o_side | output | 8 | Buy/sell indicator |
| o_qty | output | 32 | Share quantity (added, executed or cancelled) |
| o_symbol | output | 64 | Eight-character symbol |
| o_price | output | 32 | Price |
| o_match_id | output | 64 | Match number |
| o_event | output | 8 | System event code |
| o_market | output | 8 | Market category |
| o_fin_status | output | 8 | Financial status |
| o_lot_size | output | 32 | Round-lot size |
| o_err_count | output | ERR_W | Saturating error count |

## Verification
With the start edge counted as edge 0, a message of L bytes puts its valid pulse after edge 2L-2, and the field registers are final at that same moment. A truncated message ending at byte M enters the error state at edge 2M-2 and shows the new count after edge 2M-1; a one-byte truncation and an unknown type both show it after the edge that follows the error state. The bench drives on falling edges and checks the valid pulse at every falling edge of a message, so an early, late or doubled pulse is caught. It reads fields and the error count two idle cycles after each message, which is late enough for every one of these cases. The second copy of each byte is driven inverted, so sampling on the wrong copy changes every field.

// File: rtl/mdp_pkg.sv
`timescale 1ns/1ps
package mdp_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 6;
  localparam int IDX_W  = 6;
  localparam int KINDS  = 5;

  localparam logic [BYTE_W-1:0] T_ADD  = 8'h41;
  localparam logic [BYTE_W-1:0] T_EXEC = 8'h45;
  localparam logic [BYTE_W-1:0] T_CXL  = 8'h58;
  localparam logic [BYTE_W-1:0] T_SYS  = 8'h53;
  localparam logic [BYTE_W-1:0] T_DIR  = 8'h52;

  typedef enum logic [1:0] {ST_IDLE, ST_COUNT, ST_DONE, ST_ERR} seq_st_e;

  typedef enum logic [3:0] {
    F_NONE, F_REF, F_SIDE, F_QTY, F_SYM, F_PRICE,
    F_MATCH, F_EVENT, F_MARKET, F_FIN, F_LOT
  } fld_e;

  typedef struct packed {
    fld_e       id;
    logic [2:0] lane;   // byte significance inside the field, 0 = least
  } slot_t;

  // total length in bytes including the type byte; 0 marks an unknown type
  function automatic logic [LEN_W-1:0] msg_len(input logic [BYTE_W-1:0] t);
    case (t)
      T_ADD:   return LEN_W'(36);
      T_EXEC:  return LEN_W'(31);
      T_CXL:   return LEN_W'(23);
      T_SYS:   return LEN_W'(12);
      T_DIR:   return LEN_W'(39);
      default: return '0;
    endcase
  endfunction

  function automatic logic [KINDS-1:0] kind_onehot(input logic [BYTE_W-1:0] t);
    case (t)
      T_ADD:   return KINDS'(1);
      T_EXEC:  return KINDS'(2);
      T_CXL:   return KINDS'(4);
      T_SYS:   return KINDS'(8);
      T_DIR:   return KINDS'(16);
      default: return '0;
    endcase
  endfunction

  function automatic logic in_rng(input logic [IDX_W-1:0] idx, input int lo, input int hi);
    return (int'(idx) >= lo) && (int'(idx) <= hi);
  endfunction

  function automatic slot_t span(input fld_e id, input logic [IDX_W-1:0] idx, input int last);
    slot_t s;
    s.id   = id;
    s.lane = 3'(last - int'(idx));
    return s;
  endfunction

  // which field, and which byte of it, a payload byte index lands in
  function automatic slot_t slot_of(input logic [BYTE_W-1:0] t, input logic [IDX_W-1:0] idx);
    slot_t s;
    s.id   = F_NONE;
    s.lane = 3'd0;
    case (t)
      T_ADD: begin
        if      (in_rng(idx, 11, 18)) s = span(F_REF,   idx, 18);
        else if (in_rng(idx, 19, 19)) s = span(F_SIDE,  idx, 19);
        else if (in_rng(idx, 20, 23)) s = span(F_QTY,   idx, 23);
        else if (in_rng(idx, 24, 31)) s = span(F_SYM,   idx, 31);
        else if (in_rng(idx, 32, 35)) s = span(F_PRICE, idx, 35);
      end
      T_EXEC: begin
        if      (in_rng(idx, 11, 18)) s = span(F_REF,   idx, 18);
        else if (in_rng(idx, 19, 22)) s = span(F_QTY,   idx, 22);
        else if (in_rng(idx, 23, 30)) s = span(F_MATCH, idx, 30);
      end
      T_CXL: begin
        if      (in_rng(idx, 11, 18)) s = span(F_REF,   idx, 18);
        else if (in_rng(idx, 19, 22)) s = span(F_QTY,   idx, 22);
      end
      T_SYS: begin
        if (in_rng(idx, 11, 11)) s = span(F_EVENT, idx, 11);
      end
      T_DIR: begin
        if      (in_rng(idx, 11, 18)) s = span(F_SYM,    idx, 18);
        else if (in_rng(idx, 19, 19)) s = span(F_MARKET, idx, 19);
        else if (in_rng(idx, 20, 20)) s = span(F_FIN,    idx, 20);
        else if (in_rng(idx, 21, 24)) s = span(F_LOT,    idx, 24);
      end
      default: s.id = F_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/mdp_seq.sv
`timescale 1ns/1ps
module mdp_seq
  import mdp_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_start,
  input  logic              in_valid,
  input  logic              in_end,
  input  logic [BYTE_W-1:0] in_data,
  output logic [BYTE_W-1:0] o_type,
  output logic              o_cap_fire,
  output logic [IDX_W-1:0]  o_byte_idx,
  output logic              o_done,
  output logic              o_err_evt
);
  seq_st_e          st;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] len;

  // decide on the counter value that the increment is about to produce
  function automatic logic last_due(input logic [CNT_W-1:0] c, input logic [LEN_W-1:0] l);
    logic [CNT_W:0] nxt;
    logic [CNT_W:0] lim;
    nxt = {1'b0, c} + 1'b1;
    lim = (CNT_W+1)'({l, 1'b0}) - (CNT_W+1)'(2);
    return nxt >= lim;
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [CNT_W-1:0] c);
    return IDX_W'((c >> 1) + 1'b1);
  endfunction

  logic             w_start;
  logic [LEN_W-1:0] w_new_len;
  assign w_start   = in_start & in_valid;
  assign w_new_len = msg_len(in_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      len    <= '0;
      o_type <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: begin
          if (w_start) begin
            o_type <= in_data;
            len    <= w_new_len;
            cnt    <= '0;
            st     <= (w_new_len != '0) ? ST_COUNT : ST_ERR;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_COUNT: begin
          cnt <= cnt + 1'b1;
          if (last_due(cnt, len))        st <= ST_DONE;
          else if (in_valid && in_end)   st <= ST_ERR;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign o_cap_fire = (st == ST_COUNT) && cnt[0];
  assign o_byte_idx = idx_of(cnt);
  assign o_done     = (st == ST_DONE);
  assign o_err_evt  = (st == ST_ERR);
endmodule

// File: rtl/mdp_fields.sv
`timescale 1ns/1ps
module mdp_fields
  import mdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_fire,
  input  logic [BYTE_W-1:0] typ,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [BYTE_W-1:0] din,
  output logic [63:0]       o_ref,
  output logic [7:0]        o_side,
  output logic [31:0]       o_qty,
  output logic [63:0]       o_sym,
  output logic [31:0]       o_price,
  output logic [63:0]       o_match,
  output logic [7:0]        o_event,
  output logic [7:0]        o_market,
  output logic [7:0]        o_fin,
  output logic [31:0]       o_lot
);
  slot_t s;
  always_comb s = slot_of(typ, byte_idx);

  // registers are cleared only by reset, never between messages
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_ref <= '0; o_side <= '0; o_qty <= '0; o_sym <= '0; o_price <= '0;
      o_match <= '0; o_event <= '0; o_market <= '0; o_fin <= '0; o_lot <= '0;
    end else if (cap_fire) begin
      case (s.id)
        F_REF:    o_ref[{s.lane, 3'b000} +: 8]        <= din;
        F_SIDE:   o_side                              <= din;
        F_QTY:    o_qty[{s.lane[1:0], 3'b000} +: 8]   <= din;
        F_SYM:    o_sym[{s.lane, 3'b000} +: 8]        <= din;
        F_PRICE:  o_price[{s.lane[1:0], 3'b000} +: 8] <= din;
        F_MATCH:  o_match[{s.lane, 3'b000} +: 8]      <= din;
        F_EVENT:  o_event                             <= din;
        F_MARKET: o_market                            <= din;
        F_FIN:    o_fin                               <= din;
        F_LOT:    o_lot[{s.lane[1:0], 3'b000} +: 8]   <= din;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/mdp_sat_cnt.sv
`timescale 1ns/1ps
module mdp_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] o_count
);
  always_ff @(posedge clk) begin
    if (!rst_n)                     o_count <= '0;
    else if (inc && o_count != '1)  o_count <= o_count + 1'b1;
  end
endmodule

// File: rtl/mdp_parser.sv
`timescale 1ns/1ps
module mdp_parser
  import mdp_pkg::*;
#(
  parameter int ERR_W = 16,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_start,
  input  logic             in_valid,
  input  logic             in_end,
  input  logic [7:0]       in_data,
  output logic             o_msg_valid,
  output logic [4:0]       o_kind_valid,
  output logic [7:0]       o_msg_type,
  output logic [63:0]      o_order_ref,
  output logic [7:0]       o_side,
  output logic [31:0]      o_qty,
  output logic [63:0]      o_symbol,
  output logic [31:0]      o_price,
  output logic [63:0]      o_match_id,
  output logic [7:0]       o_event,
  output logic [7:0]       o_market,
  output logic [7:0]       o_fin_status,
  output logic [31:0]      o_lot_size,
  output logic [ERR_W-1:0] o_err_count
);
  logic             w_cap_fire;
  logic [IDX_W-1:0] w_byte_idx;
  logic             w_done;
  logic             w_err_evt;
  logic [7:0]       w_type;

  mdp_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_start(in_start), .in_valid(in_valid), .in_end(in_end), .in_data(in_data),
    .o_type(w_type), .o_cap_fire(w_cap_fire), .o_byte_idx(w_byte_idx),
    .o_done(w_done), .o_err_evt(w_err_evt)
  );

  mdp_fields u_fields (
    .clk(clk), .rst_n(rst_n),
    .cap_fire(w_cap_fire), .typ(w_type), .byte_idx(w_byte_idx), .din(in_data),
    .o_ref(o_order_ref), .o_side(o_side), .o_qty(o_qty), .o_sym(o_symbol),
    .o_price(o_price), .o_match(o_match_id), .o_event(o_event),
    .o_market(o_market), .o_fin(o_fin_status), .o_lot(o_lot_size)
  );

  mdp_sat_cnt #(.W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .inc(w_err_evt), .o_count(o_err_count)
  );

  assign o_msg_valid  = w_done;
  assign o_kind_valid = w_done ? kind_onehot(w_type) : '0;
  assign o_msg_type   = w_type;
endmodule

// File: rtl/mdp_parser_chk.sv
`timescale 1ns/1ps
module mdp_parser_chk #(
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic [4:0]       kind_valid,
  input logic [ERR_W-1:0] err_count,
  input logic             cap_fire,
  input logic             err_evt,
  input logic [63:0]      ref_q,
  input logic [63:0]      sym_q,
  input logic [31:0]      lot_q,
  input logic [7:0]       event_q
);
  AST_KIND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $countones(kind_valid) == 1);                                  // R3
  AST_KIND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |-> kind_valid == '0);                                            // R3
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> !msg_valid);                                                   // R2
  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && err_count != '1) |=> err_count == ERR_W'($past(err_count) + 1'b1)); // R9
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !err_evt |=> $stable(err_count));                                            // R10
  AST_ERR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    err_count == '1 |=> err_count == '1);                                        // R11
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> ($stable(ref_q) && $stable(sym_q) && $stable(lot_q) && $stable(event_q))); // R8
endmodule

bind mdp_parser mdp_parser_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(o_msg_valid), .kind_valid(o_kind_valid),
  .err_count(o_err_count), .cap_fire(w_cap_fire), .err_evt(w_err_evt),
  .ref_q(o_order_ref), .sym_q(o_symbol), .lot_q(o_lot_size), .event_q(o_event)
);

// File: tb/test_mdp_parser.sv
`timescale 1ns/1ps
module test_mdp_parser;
  localparam int EW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_start = 1'b0, in_valid = 1'b0, in_end = 1'b0;
  logic [7:0] in_data = '0;
  logic o_msg_valid;
  logic [4:0] o_kind_valid;
  logic [7:0] o_msg_type, o_side, o_event, o_market, o_fin_status;
  logic [63:0] o_order_ref, o_symbol, o_match_id;
  logic [31:0] o_qty, o_price, o_lot_size;
  logic [EW-1:0] o_err_count;

  always #10 clk = ~clk;

  mdp_parser #(.ERR_W(EW)) i_mdp_parser (
    .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_valid(in_valid), .in_end(in_end),
    .in_data(in_data), .o_msg_valid(o_msg_valid), .o_kind_valid(o_kind_valid),
    .o_msg_type(o_msg_type), .o_order_ref(o_order_ref), .o_side(o_side), .o_qty(o_qty),
    .o_symbol(o_symbol), .o_price(o_price), .o_match_id(o_match_id), .o_event(o_event),
    .o_market(o_market), .o_fin_status(o_fin_status), .o_lot_size(o_lot_size),
    .o_err_count(o_err_count)
  );

  int n_chk = 0, n_bad = 0;
  logic [63:0] m_ref = '0, m_sym = '0, m_match = '0;
  logic [31:0] m_qty = '0, m_price = '0, m_lot = '0;
  logic [7:0]  m_side = '0, m_event = '0, m_market = '0, m_fin = '0;
  logic [EW-1:0] m_err = '0;
  logic [7:0] mb [0:38];
  bit pend = 0;
  logic [4:0] pend_kind = '0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int model_len(input logic [7:0] t);
    case (t)
      8'h41: return 36;  8'h45: return 31;  8'h58: return 23;
      8'h53: return 12;  8'h52: return 39;  default: return 0;
    endcase
  endfunction

  function automatic logic [4:0] model_kind(input logic [7:0] t);
    case (t)
      8'h41: return 5'b00001;  8'h45: return 5'b00010;  8'h58: return 5'b00100;
      8'h53: return 5'b01000;  8'h52: return 5'b10000;  default: return 5'b00000;
    endcase
  endfunction

  // own statement of the field layouts; big-endian: lower byte number = higher bits
  task automatic model_byte(input logic [7:0] t, input int i, input logic [7:0] b);
    case (t)
      8'h41: begin
        if (i >= 11 && i <= 18)      m_ref[8*(18-i) +: 8] = b;
        else if (i == 19)            m_side = b;
        else if (i >= 20 && i <= 23) m_qty[8*(23-i) +: 8] = b;
        else if (i >= 24 && i <= 31) m_sym[8*(31-i) +: 8] = b;
        else if (i >= 32 && i <= 35) m_price[8*(35-i) +: 8] = b;
      end
      8'h45: begin
        if (i >= 11 && i <= 18)      m_ref[8*(18-i) +: 8] = b;
        else if (i >= 19 && i <= 22) m_qty[8*(22-i) +: 8] = b;
        else if (i >= 23 && i <= 30) m_match[8*(30-i) +: 8] = b;
      end
      8'h58: begin
        if (i >= 11 && i <= 18)      m_ref[8*(18-i) +: 8] = b;
        else if (i >= 19 && i <= 22) m_qty[8*(22-i) +: 8] = b;
      end
      8'h53: if (i == 11) m_event = b;
      8'h52: begin
        if (i >= 11 && i <= 18)      m_sym[8*(18-i) +: 8] = b;
        else if (i == 19)            m_market = b;
        else if (i == 20)            m_fin = b;
        else if (i >= 21 && i <= 24) m_lot[8*(24-i) +: 8] = b;
      end
      default: ;
    endcase
  endtask

  task automatic check_fields(input string tag);
    chk({tag, " ref"},    o_order_ref,  m_ref);
    chk({tag, " side"},   64'(o_side),  64'(m_side));
    chk({tag, " qty"},    64'(o_qty),   64'(m_qty));
    chk({tag, " sym"},    o_symbol,     m_sym);
    chk({tag, " price"},  64'(o_price), 64'(m_price));
    chk({tag, " match"},  o_match_id,   m_match);
    chk({tag, " event"},  64'(o_event), 64'(m_event));
    chk({tag, " market"}, 64'(o_market), 64'(m_market));
    chk({tag, " fin"},    64'(o_fin_status), 64'(m_fin));
    chk({tag, " lot"},    64'(o_lot_size), 64'(m_lot));
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    in_start = 0; in_end = 0; in_valid = 0; in_data = 8'h00;
  endtask

  // send `sent` bytes of a message of type t; second copy of each byte is inverted (R4)
  task automatic send(input logic [7:0] t, input int sent, input int seed,
                      input bit skip_tail, input string tag);
    int  len = model_len(t);
    bit  known = (len != 0);
    bit  complete = known && (sent == len);
    int  ncyc = 2*sent - (skip_tail ? 1 : 0);
    bit  exp_v;
    mb[0] = t;
    for (int i = 1; i < 39; i++) mb[i] = 8'(seed*37 + i*11 + 5);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      exp_v = (c == 0 && pend) || (complete && c == 2*len-1);
      chk((c == 0 && pend) ? "R12 valid" : "R2 valid", 64'(o_msg_valid), 64'(exp_v));
      if (c == 0 && pend)  chk("R12 kind", 64'(o_kind_valid), 64'(pend_kind));
      else if (exp_v)      chk("R3 kind",  64'(o_kind_valid), 64'(model_kind(t)));
      else                 chk("R3 quiet", 64'(o_kind_valid), 64'(0));
      in_valid = 1;
      in_start = (c == 0);
      in_end   = (c >= 2*sent-2);
      in_data  = (c % 2 == 1) ? ~mb[c/2] : mb[c/2];
    end
    if (known) for (int i = 1; i < sent; i++) model_byte(t, i, mb[i]);
    if (!known || sent < len) m_err = (m_err == '1) ? m_err : m_err + 1'b1;
    pend = skip_tail && complete;
    pend_kind = model_kind(t);
    if (!skip_tail) begin
      for (int k = 0; k < 2; k++) begin
        idle_cycle();
        if (k == 0) chk("R2 after", 64'(o_msg_valid), 64'(complete && 2*sent-1 == 2*len-1 && 0));
      end
      chk("R2 nopulse", 64'(o_msg_valid), 64'(0));
      chk({tag, " type"}, 64'(o_msg_type), 64'(t));
      check_fields(tag);
      chk((m_err == '1) ? "R11 errcnt" : (known ? "R10 errcnt" : "R9 errcnt"),
          64'(o_err_count), 64'(m_err));
    end
  endtask

  function automatic string tag_of(input logic [7:0] t);
    case (t)
      8'h41: return "R5";
      8'h45, 8'h58: return "R6";
      default: return "R7";
    endcase
  endfunction

  logic [7:0] kinds [0:4];

  initial begin
    kinds[0] = 8'h41; kinds[1] = 8'h45; kinds[2] = 8'h58; kinds[3] = 8'h53; kinds[4] = 8'h52;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid", 64'(o_msg_valid), 0);
    chk("R1 kind",  64'(o_kind_valid), 0);
    chk("R1 type",  64'(o_msg_type), 0);
    chk("R1 err",   64'(o_err_count), 0);
    check_fields("R1");

    // every type, several byte patterns
    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 5; k++) send(kinds[k], model_len(kinds[k]), s*5 + k + 1, 0, tag_of(kinds[k]));

    // retention while bytes arrive with no start flag
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      in_valid = 1; in_start = 0; in_end = (c == 23); in_data = 8'(c*29 + 3);
    end
    repeat (3) idle_cycle();
    check_fields("R8");
    chk("R8 nopulse", 64'(o_msg_valid), 0);
    chk("R8 err", 64'(o_err_count), 64'(m_err));

    // back-to-back: next start in the completion cycle
    send(8'h41, 36, 40, 1, "R12");
    send(8'h45, 31, 41, 1, "R12");
    send(8'h53, 12, 42, 0, "R12");

    // every truncation length of every type
    for (int k = 0; k < 5; k++)
      for (int m = 1; m < model_len(kinds[k]); m++) send(kinds[k], m, 50 + m, 0, "R10");

    // every unknown type byte; the count passes saturation (R11)
    for (int v = 0; v < 256; v++)
      if (model_len(8'(v)) == 0) send(8'(v), 1, v, 0, "R9");
    chk("R11 saturated", 64'(o_err_count), 64'(8'hFF));

    // parsing still works after saturation
    send(8'h52, 39, 77, 0, "R7");
    send(8'h58, 23, 78, 0, "R6");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog got=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule